// File: doc/BRIEF.md
# Three-Multiplier Complex Product Pipeline

This block multiplies two signed complex numbers, x = xr + j·xi and y = yr + j·yi, and returns both parts of the product at full precision. It needs only three real multiplications per product. One term, the difference of the first operand's parts times the second operand's imaginary part, is computed once and added into both outputs. The real part is the second operand's part difference (yr − yi) times xr, plus the shared term. The imaginary part is the sum (yr + yi) times xi, plus the shared term.

The datapath has four register stages. The first captures the operands. The second holds the pre-adder results. The third holds the three products. The fourth holds the two output sums. The widths are set so that each multiply uses one operand of at most 17 bits and one of at most 16 bits, which fits a 27x18 signed hardware multiplier. The pipeline advances every cycle and never stalls. A qualifier travels alongside the data. Reset clears only that qualifier, never the data registers.

Top module: `cmul3_top`

## Requirements
- R1: When `out_valid` is 1, `out_re` equals xr·yr − xi·yi for the operands accepted four clock edges earlier, as an exact signed two's-complement value.
- R2: When `out_valid` is 1, `out_im` equals xr·yi + xi·yr for the operands accepted four clock edges earlier, as an exact signed two's-complement value.
- R3: An `in_valid` of 1 sampled at a clock edge produces `out_valid` = 1 exactly four edges later, provided no reset occurs in between.
- R4: Operands presented on consecutive cycles produce results on consecutive cycles, in the same order. No cycle is lost.
- R5: While `rst` is 1 at an edge, every in-flight qualifier is cleared and `in_valid` is ignored. `out_valid` stays 0 until four clean edges have passed after reset.
- R6: Operands at the extremes of the 16-bit range (−32768 and 32767, in any combination) give exact results with no overflow in the 35-bit outputs.
- R7: A cycle with `in_valid` = 0 produces `out_valid` = 0 four edges later. Gaps in the input stream are preserved as gaps in the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers sample on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the qualifier pipeline |
| in_valid | input | 1 | Operands on this cycle form a product to be computed |
| xr | input | 16 | First operand real part, signed |
| xi | input | 16 | First operand imaginary part, signed |
| yr | input | 16 | Second operand real part, signed |
| yi | input | 16 | Second operand imaginary part, signed |
| out_valid | output | 1 | `out_re`/`out_im` hold a product |
| out_re | output | 35 | Real part of the product, signed |
| out_im | output | 35 | Imaginary part of the product, signed |

## Verification
The qualifier clear and the arrival of a new operand can fall on the same edge, while older products are still half-way down the pipe. The bench provokes this by raising `rst` in a cycle where `in_valid` is 1 and three earlier products are in flight. A cycle-by-cycle model of the pipe then expects `out_valid` to stay 0 for the next four cycles, even though the data stages keep moving. It also expects the first product issued after the clear to come out with exact values and the normal four-edge delay.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;

    // Default operand width and structural constants of the product pipe.
    localparam int unsigned CM_IN_W      = 16;
    localparam int unsigned CM_LATENCY   = 4;
    localparam int unsigned CM_NUM_MULT  = 3;

    // Multiplier slot assignment.
    localparam int unsigned CM_IX_SHARED = 0;
    localparam int unsigned CM_IX_REAL   = 1;
    localparam int unsigned CM_IX_IMAG   = 2;

    // A sum or difference of two w-bit values needs one more bit.
    function automatic int unsigned cm_pre_w(input int unsigned w);
        return w + 1;
    endfunction

    // A signed product needs the sum of the operand widths.
    function automatic int unsigned cm_prod_w(input int unsigned aw, input int unsigned bw);
        return aw + bw;
    endfunction

endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd #(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned PRE_W = 17
) (
    input  logic              clk,
    input  logic [IN_W-1:0]   xr_i,
    input  logic [IN_W-1:0]   xi_i,
    input  logic [IN_W-1:0]   yr_i,
    input  logic [IN_W-1:0]   yi_i,
    output logic [PRE_W-1:0]  xdiff_o,
    output logic [PRE_W-1:0]  ydiff_o,
    output logic [PRE_W-1:0]  ysum_o,
    output logic [IN_W-1:0]   xr_o,
    output logic [IN_W-1:0]   xi_o,
    output logic [IN_W-1:0]   yi_o
);

    // Stage 1: captured operands.
    typedef struct packed {
        logic [IN_W-1:0] xr;
        logic [IN_W-1:0] xi;
        logic [IN_W-1:0] yr;
        logic [IN_W-1:0] yi;
    } opnd_t;

    // Stage 2: pre-adder results plus the operands the multipliers still need.
    typedef struct packed {
        logic [PRE_W-1:0] xdiff;
        logic [PRE_W-1:0] ydiff;
        logic [PRE_W-1:0] ysum;
        logic [IN_W-1:0]  xr;
        logic [IN_W-1:0]  xi;
        logic [IN_W-1:0]  yi;
    } pre_t;

    opnd_t opnd_d, opnd_q;
    pre_t  pre_d,  pre_q;

    always_comb begin
        opnd_d.xr = xr_i;
        opnd_d.xi = xi_i;
        opnd_d.yr = yr_i;
        opnd_d.yi = yi_i;

        pre_d.xdiff = PRE_W'($signed(opnd_q.xr)) - PRE_W'($signed(opnd_q.xi));
        pre_d.ydiff = PRE_W'($signed(opnd_q.yr)) - PRE_W'($signed(opnd_q.yi));
        pre_d.ysum  = PRE_W'($signed(opnd_q.yr)) + PRE_W'($signed(opnd_q.yi));
        pre_d.xr    = opnd_q.xr;
        pre_d.xi    = opnd_q.xi;
        pre_d.yi    = opnd_q.yi;
    end

    // Data registers carry no reset.
    always_ff @(posedge clk) begin
        opnd_q <= opnd_d;
        pre_q  <= pre_d;
    end

    assign xdiff_o = pre_q.xdiff;
    assign ydiff_o = pre_q.ydiff;
    assign ysum_o  = pre_q.ysum;
    assign xr_o    = pre_q.xr;
    assign xi_o    = pre_q.xi;
    assign yi_o    = pre_q.yi;

endmodule

// File: rtl/cmul3_mult.sv
module cmul3_mult #(
    parameter int unsigned AW = 16,
    parameter int unsigned BW = 17,
    localparam int unsigned PW = AW + BW
) (
    input  logic          clk,
    input  logic [AW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    output logic [PW-1:0] p_o
);

    typedef struct packed {
        logic [PW-1:0] prod;
    } mul_t;

    mul_t mul_d, mul_q;

    always_comb begin
        mul_d.prod = PW'($signed(a_i)) * PW'($signed(b_i));
    end

    always_ff @(posedge clk) begin
        mul_q <= mul_d;
    end

    assign p_o = mul_q.prod;

endmodule

// File: rtl/cmul3_sum.sv
module cmul3_sum #(
    parameter int unsigned PROD_W = 33,
    parameter int unsigned OUT_W  = 35
) (
    input  logic              clk,
    input  logic [PROD_W-1:0] shared_i,
    input  logic [PROD_W-1:0] preal_i,
    input  logic [PROD_W-1:0] pimag_i,
    output logic [OUT_W-1:0]  re_o,
    output logic [OUT_W-1:0]  im_o
);

    typedef struct packed {
        logic [OUT_W-1:0] re;
        logic [OUT_W-1:0] im;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d.re = OUT_W'($signed(preal_i)) + OUT_W'($signed(shared_i));
        res_d.im = OUT_W'($signed(pimag_i)) + OUT_W'($signed(shared_i));
    end

    always_ff @(posedge clk) begin
        res_q <= res_d;
    end

    assign re_o = res_q.re;
    assign im_o = res_q.im;

endmodule

// File: rtl/cmul3_vpipe.sv
module cmul3_vpipe #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic v_i,
    output logic v_o
);

    typedef struct packed {
        logic [DEPTH-1:0] stage;
    } vp_t;

    vp_t vp_d, vp_q;

    always_comb begin
        vp_d.stage = {vp_q.stage[DEPTH-2:0], v_i};
    end

    // Only the qualifier is reset; data stages run free.
    always_ff @(posedge clk) begin
        if (rst) begin
            vp_q.stage <= '0;
        end else begin
            vp_q <= vp_d;
        end
    end

    assign v_o = vp_q.stage[DEPTH-1];

endmodule

// File: rtl/cmul3_top.sv
module cmul3_top
    import cmul3_pkg::*;
#(
    parameter int unsigned  IN_W  = CM_IN_W,
    localparam int unsigned OUT_W = 2 * IN_W + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  xr,
    input  logic signed [IN_W-1:0]  xi,
    input  logic signed [IN_W-1:0]  yr,
    input  logic signed [IN_W-1:0]  yi,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_re,
    output logic signed [OUT_W-1:0] out_im
);

    localparam int unsigned PRE_W  = cm_pre_w(IN_W);
    localparam int unsigned PROD_W = cm_prod_w(IN_W, PRE_W);

    logic [PRE_W-1:0] xdiff, ydiff, ysum;
    logic [IN_W-1:0]  xr_p, xi_p, yi_p;

    logic [IN_W-1:0]   mul_a [CM_NUM_MULT];
    logic [PRE_W-1:0]  mul_b [CM_NUM_MULT];
    logic [PROD_W-1:0] mul_p [CM_NUM_MULT];

    logic [OUT_W-1:0] re_raw, im_raw;

    cmul3_preadd #(.IN_W(IN_W), .PRE_W(PRE_W)) u_preadd (
        .clk     (clk),
        .xr_i    (xr),
        .xi_i    (xi),
        .yr_i    (yr),
        .yi_i    (yi),
        .xdiff_o (xdiff),
        .ydiff_o (ydiff),
        .ysum_o  (ysum),
        .xr_o    (xr_p),
        .xi_o    (xi_p),
        .yi_o    (yi_p)
    );

    // Shared term: (xr - xi) * yi; real: (yr - yi) * xr; imag: (yr + yi) * xi.
    always_comb begin
        mul_a[CM_IX_SHARED] = yi_p;
        mul_b[CM_IX_SHARED] = xdiff;
        mul_a[CM_IX_REAL]   = xr_p;
        mul_b[CM_IX_REAL]   = ydiff;
        mul_a[CM_IX_IMAG]   = xi_p;
        mul_b[CM_IX_IMAG]   = ysum;
    end

    for (genvar k = 0; k < CM_NUM_MULT; k++) begin : g_mul
        cmul3_mult #(.AW(IN_W), .BW(PRE_W)) u_mul (
            .clk (clk),
            .a_i (mul_a[k]),
            .b_i (mul_b[k]),
            .p_o (mul_p[k])
        );
    end

    cmul3_sum #(.PROD_W(PROD_W), .OUT_W(OUT_W)) u_sum (
        .clk      (clk),
        .shared_i (mul_p[CM_IX_SHARED]),
        .preal_i  (mul_p[CM_IX_REAL]),
        .pimag_i  (mul_p[CM_IX_IMAG]),
        .re_o     (re_raw),
        .im_o     (im_raw)
    );

    cmul3_vpipe #(.DEPTH(CM_LATENCY)) u_vpipe (
        .clk (clk),
        .rst (rst),
        .v_i (in_valid),
        .v_o (out_valid)
    );

    assign out_re = $signed(re_raw);
    assign out_im = $signed(im_raw);

endmodule

// File: rtl/cmul3_chk.sv
module cmul3_chk #(
    parameter int unsigned  IN_W  = 16,
    localparam int unsigned OUT_W = 2 * IN_W + 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic signed [IN_W-1:0]  xr,
    input logic signed [IN_W-1:0]  xi,
    input logic signed [IN_W-1:0]  yr,
    input logic signed [IN_W-1:0]  yi,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_re,
    input logic signed [OUT_W-1:0] out_im
);

    // Clean edges since the last reset edge, saturating at the pipe depth.
    logic [2:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)               age_q <= 3'd0;
        else if (age_q != 3'd4) age_q <= age_q + 3'd1;
    end

    // Four-multiplier textbook form, independent of the three-multiplier datapath.
    logic signed [OUT_W-1:0] ref_re, ref_im;
    always_comb begin
        ref_re = OUT_W'(xr) * OUT_W'(yr) - OUT_W'(xi) * OUT_W'(yi);
        ref_im = OUT_W'(xr) * OUT_W'(yi) + OUT_W'(xi) * OUT_W'(yr);
    end

    assert_real_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_re == $past(ref_re, 4));

    assert_imag_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_im == $past(ref_im, 4));

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'd4 && $past(in_valid, 4)) |-> out_valid);

    assert_clear_R5: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_settle_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> age_q == 3'd4);

    assert_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'd4 && !$past(in_valid, 4)) |-> !out_valid);

endmodule

bind cmul3_top cmul3_chk #(.IN_W(IN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .xr        (xr),
    .xi        (xi),
    .yr        (yr),
    .yi        (yi),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/tb_cmul3_top.sv
module tb_cmul3_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] xr = '0, xi = '0, yr = '0, yi = '0;
    logic out_valid;
    logic signed [34:0] out_re, out_im;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    cmul3_top dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .xr        (xr),
        .xi        (xi),
        .yr        (yr),
        .yi        (yi),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    // Behavioural model: a queue of four pipeline slots, front = newest.
    typedef struct {
        bit     v;
        longint re;
        longint im;
        bit     ext;
    } exp_t;

    exp_t pipe[$];

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model at the rising edge,
    // then compare at the next falling edge.
    task automatic step(input bit v, input int a, input int b, input int c, input int d,
                        input bit r, input bit ext, input string tag);
        exp_t e;
        in_valid = v;
        rst      = r;
        xr = 16'(a); xi = 16'(b); yr = 16'(c); yi = 16'(d);
        @(posedge clk);
        e.v   = v && !r;
        e.re  = longint'(a) * longint'(c) - longint'(b) * longint'(d);
        e.im  = longint'(a) * longint'(d) + longint'(b) * longint'(c);
        e.ext = ext;
        if (r) begin
            foreach (pipe[k]) pipe[k].v = 1'b0;
        end
        pipe.push_front(e);
        void'(pipe.pop_back());
        @(negedge clk);
        chk({tag, " out_valid"}, longint'(out_valid), longint'(pipe[3].v));
        if (pipe[3].v && out_valid) begin
            chk(pipe[3].ext ? "R6 real" : "R1 real", longint'(out_re), pipe[3].re);
            chk(pipe[3].ext ? "R6 imag" : "R2 imag", longint'(out_im), pipe[3].im);
        end
    endtask

    function automatic int rnd16();
        return int'($urandom_range(65535)) - 32768;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            exp_t z;
            z.v = 1'b0; z.re = 0; z.im = 0; z.ext = 1'b0;
            pipe.push_back(z);
        end
        @(negedge clk);

        // R5: reset with in_valid held high is ignored; output stays low afterwards.
        for (int k = 0; k < 3; k++) step(1'b1, 5, 6, 7, 8, 1'b1, 1'b0, "R5");
        for (int k = 0; k < 4; k++) step(1'b0, 0, 0, 0, 0, 1'b0, 1'b0, "R5");

        // R3: one isolated product, then idle cycles.
        step(1'b1, 3, -4, 5, 7, 1'b0, 1'b0, "R3");
        for (int k = 0; k < 6; k++) step(1'b0, 1, 1, 1, 1, 1'b0, 1'b0, "R3");

        // R4: a back-to-back stream of products.
        for (int k = 0; k < 24; k++) step(1'b1, rnd16(), rnd16(), rnd16(), rnd16(), 1'b0, 1'b0, "R4");

        // R7: gaps in the stream must reappear as gaps.
        for (int k = 0; k < 16; k++)
            step(k % 3 != 1, rnd16(), rnd16(), rnd16(), rnd16(), 1'b0, 1'b0, "R7");

        // R6: all extreme-value combinations.
        for (int m = 0; m < 16; m++)
            step(1'b1, m[0] ? 32767 : -32768, m[1] ? 32767 : -32768,
                 m[2] ? 32767 : -32768, m[3] ? 32767 : -32768, 1'b0, 1'b1, "R6");
        step(1'b1, -32768, -32768, -32768, 32767, 1'b0, 1'b1, "R6");
        for (int k = 0; k < 4; k++) step(1'b0, 0, 0, 0, 0, 1'b0, 1'b0, "R6");

        // R5: reset falls on an edge with a new operand and three products in flight.
        for (int k = 0; k < 3; k++) step(1'b1, rnd16(), rnd16(), rnd16(), rnd16(), 1'b0, 1'b0, "R4");
        step(1'b1, 100, 200, 300, 400, 1'b1, 1'b0, "R5");
        step(1'b1, -9, 11, 13, -15, 1'b0, 1'b0, "R5");
        for (int k = 0; k < 6; k++) step(1'b0, 0, 0, 0, 0, 1'b0, 1'b0, "R5");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule